// File: doc/BRIEF.md
# Millimetre-Wave Transmit Frame Builder with Beam-Training Tail

This block assembles one complete transmit frame per start command. Only the payload samples come from outside, through a valid/ready stream fed by a buffer memory. The block generates the two preamble fields on its own from small computed waveform tables. It places them ahead of the payload, passes the payload through, and then appends a configurable number of beam-training fields. The finished frame leaves on a sample stream that feeds the DAC channelizer.

During each training field the block drives an antenna weight vector index, so that every training field goes out on its own beam pattern. Outside the training tail the index holds the configured data beam. The configuration is the field lengths, the training field count and the data beam index. It is sampled on the edge that accepts the start command and stays frozen for the whole frame.

The controller is a state machine with the states IDLE, STF (short training), CEF (channel estimation), PAY (payload), TRN (training) and DONE. The transitions are as follows. IDLE→STF on start. STF→CEF when the short-training count is reached. CEF→PAY when the channel-estimation count is reached. PAY→TRN when the payload count is reached or a word marked last is accepted. PAY→DONE on the same payload-end condition when the training count is zero. TRN→TRN at each field boundary while fields remain. TRN→DONE after the last sample of the last field. DONE→IDLE unconditionally.

Top module: `mmw_tx_framer`

## Requirements
- R1: After reset, out_valid and pay_ready are 0, out_field is 0 (IDLE) and awv_idx is 0.
- R2: A start seen in IDLE makes the frame begin on the next cycle. The fields follow in the order STF, CEF, PAY, TRN, DONE, then IDLE. out_field carries the field code: IDLE=0, STF=1, CEF=2, PAY=3, TRN=4, DONE=5.
- R3: STF emits exactly cfg_stf_len samples and CEF emits exactly cfg_cef_len samples, with out_valid high on each. Sample i of a field is −8192 if the XOR of the bits of ((i mod 32) AND mask) is 1, and +8192 otherwise. The mask is 0x13 for STF and 0x0D for CEF.
- R4: pay_ready is high only in PAY. There, out_valid equals pay_valid and out_data equals pay_data in the same cycle, so a stalled input produces no output sample.
- R5: The payload ends with the accepted word number cfg_pay_len, or earlier with an accepted word that has pay_last high. That last word is itself forwarded.
- R6: TRN emits cfg_trn_cnt fields of cfg_trn_len samples each. Within each field the sample index restarts at 0 and uses mask 0x1A with the R3 rule. A count of zero skips TRN and goes from PAY to DONE.
- R7: During training field k (counting from 0), awv_idx = (data beam + 1 + k) mod 64. In every other state of a frame, and in IDLE afterwards, awv_idx equals the data beam.
- R8: A start arriving while a frame is in progress has no effect. The frame continues unchanged, and IDLE follows DONE with no new frame.
- R9: The configuration is taken on the edge that accepts start. A length of 0 behaves as 1. A short-training length above 32 wraps the table index.
- R10: DONE lasts one cycle with out_valid 0 and is followed by IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start command |
| cfg_stf_len | input | 12 | Short training field length in samples |
| cfg_cef_len | input | 12 | Channel estimation field length in samples |
| cfg_pay_len | input | 12 | Maximum payload length in words |
| cfg_trn_len | input | 12 | Length of each training field in samples |
| cfg_trn_cnt | input | 4 | Number of training fields |
| cfg_data_awv | input | 6 | Beam index used outside training |
| pay_valid | input | 1 | Payload word valid |
| pay_data | input | 16 | Payload sample |
| pay_last | input | 1 | Marks the final payload word |
| pay_ready | output | 1 | Payload word accepted this cycle when valid |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Output sample toward the channelizer |
| out_field | output | 3 | Code of the current field |
| awv_idx | output | 6 | Antenna weight vector index |

## Verification
All outputs decode the state register and counters directly. The first STF sample therefore appears in the cycle after the edge that sees start, and a payload word shows on out_data in the same cycle it is accepted. A driver task builds each frame's expected samples, field codes and beam indices from the requirements and queues them. A monitor samples on the falling edge, so every registered change has settled, and pops one entry for each cycle with out_valid high. At each frame end the bench checks the one-cycle DONE, the return to IDLE and the restored data beam on the following falling edges.

// File: rtl/framer_pkg.sv
package framer_pkg;

    typedef enum logic [2:0] {
        FR_IDLE = 3'd0,
        FR_STF  = 3'd1,
        FR_CEF  = 3'd2,
        FR_PAY  = 3'd3,
        FR_TRN  = 3'd4,
        FR_DONE = 3'd5
    } fr_state_e;

    localparam int NUM_WAVES = 3;

    // sign-pattern masks of the generated fields (index 0 short, 1 estimation, 2 training)
    function automatic logic [15:0] wave_mask(input int sel);
        case (sel)
            0:       return 16'h0013;
            1:       return 16'h000D;
            default: return 16'h001A;
        endcase
    endfunction

endpackage

// File: rtl/framer_wave_rom.sv
module framer_wave_rom #(
    parameter int          SW    = 16,
    parameter int          DEPTH = 32,
    parameter int          AMP   = 8192,
    parameter logic [15:0] MASK  = 16'h0013,
    localparam int         IW    = $clog2(DEPTH)
) (
    input  logic [IW-1:0] idx,
    output logic [SW-1:0] sample
);
    localparam logic [SW-1:0] POS = SW'(AMP);
    localparam logic [SW-1:0] NEG = SW'(-AMP);

    logic [SW-1:0] table_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [15:0] GI = 16'(g);
        assign table_q[g] = (^(GI & MASK)) ? NEG : POS;
    end

    assign sample = table_q[idx];
endmodule

// File: rtl/framer_seq.sv
module framer_seq
    import framer_pkg::*;
#(
    parameter int LW = 12,
    parameter int CW = 4,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] cfg_stf_len,
    input  logic [LW-1:0] cfg_cef_len,
    input  logic [LW-1:0] cfg_pay_len,
    input  logic [LW-1:0] cfg_trn_len,
    input  logic [CW-1:0] cfg_trn_cnt,
    input  logic [AW-1:0] cfg_data_awv,
    input  logic          pay_valid,
    input  logic          pay_last,
    output fr_state_e     state,
    output logic [LW-1:0] cnt,
    output logic [CW-1:0] fld,
    output logic [AW-1:0] data_awv
);
    typedef struct packed {
        logic [LW-1:0] stf_len;
        logic [LW-1:0] cef_len;
        logic [LW-1:0] pay_len;
        logic [LW-1:0] trn_len;
        logic [CW-1:0] trn_cnt;
        logic [AW-1:0] awv;
    } cfg_t;

    cfg_t          cfg_q;
    fr_state_e     state_d;
    logic [LW-1:0] cnt_d;
    logic [CW-1:0] fld_d;
    logic [LW-1:0] cur_len;
    logic          cnt_end;
    logic          fld_end;

    // configuration follows the inputs while idle and freezes once a frame starts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cfg_q <= '0;
        else if (state == FR_IDLE) cfg_q <= '{cfg_stf_len, cfg_cef_len, cfg_pay_len,
                                              cfg_trn_len, cfg_trn_cnt, cfg_data_awv};
    end

    always_comb begin
        unique case (state)
            FR_STF:  cur_len = cfg_q.stf_len;
            FR_CEF:  cur_len = cfg_q.cef_len;
            FR_PAY:  cur_len = cfg_q.pay_len;
            FR_TRN:  cur_len = cfg_q.trn_len;
            default: cur_len = '0;
        endcase
    end

    // a length of zero ends after one sample, like a length of one
    assign cnt_end = ({1'b0, cnt} + 1'b1) >= {1'b0, cur_len};
    assign fld_end = ({1'b0, fld} + 1'b1) >= {1'b0, cfg_q.trn_cnt};

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        fld_d   = fld;
        unique case (state)
            FR_IDLE: begin
                if (start) begin
                    state_d = FR_STF;
                    cnt_d   = '0;
                end
            end
            FR_STF: begin
                cnt_d = cnt_end ? '0 : cnt + 1'b1;
                if (cnt_end) state_d = FR_CEF;
            end
            FR_CEF: begin
                cnt_d = cnt_end ? '0 : cnt + 1'b1;
                if (cnt_end) state_d = FR_PAY;
            end
            FR_PAY: begin
                if (pay_valid) begin
                    if (cnt_end || pay_last) begin
                        cnt_d   = '0;
                        fld_d   = '0;
                        state_d = (cfg_q.trn_cnt == '0) ? FR_DONE : FR_TRN;
                    end else begin
                        cnt_d = cnt + 1'b1;
                    end
                end
            end
            FR_TRN: begin
                if (cnt_end) begin
                    cnt_d = '0;
                    if (fld_end) state_d = FR_DONE;
                    else         fld_d   = fld + 1'b1;
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end
            FR_DONE: state_d = FR_IDLE;
            default: state_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            cnt   <= '0;
            fld   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            fld   <= fld_d;
        end
    end

    assign data_awv = cfg_q.awv;
endmodule

// File: rtl/framer_awv.sv
module framer_awv #(
    parameter int AW = 6,
    parameter int CW = 4
) (
    input  logic          in_trn,
    input  logic [CW-1:0] fld,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] awv
);
    // training field k steers to base+1+k; the sum wraps modulo 2^AW
    always_comb begin
        if (in_trn) awv = base + AW'(fld) + AW'(1);
        else        awv = base;
    end
endmodule

// File: rtl/mmw_tx_framer.sv
module mmw_tx_framer
    import framer_pkg::*;
#(
    parameter int SW    = 16,
    parameter int LW    = 12,
    parameter int CW    = 4,
    parameter int AW    = 6,
    parameter int DEPTH = 32,
    parameter int AMP   = 8192,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] cfg_stf_len,
    input  logic [LW-1:0] cfg_cef_len,
    input  logic [LW-1:0] cfg_pay_len,
    input  logic [LW-1:0] cfg_trn_len,
    input  logic [CW-1:0] cfg_trn_cnt,
    input  logic [AW-1:0] cfg_data_awv,
    input  logic          pay_valid,
    input  logic [SW-1:0] pay_data,
    input  logic          pay_last,
    output logic          pay_ready,
    output logic          out_valid,
    output logic [SW-1:0] out_data,
    output logic [2:0]    out_field,
    output logic [AW-1:0] awv_idx
);
    fr_state_e     state;
    logic [LW-1:0] cnt;
    logic [CW-1:0] fld;
    logic [AW-1:0] data_awv;
    logic [SW-1:0] wave [NUM_WAVES];

    framer_seq #(.LW(LW), .CW(CW), .AW(AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_stf_len  (cfg_stf_len),
        .cfg_cef_len  (cfg_cef_len),
        .cfg_pay_len  (cfg_pay_len),
        .cfg_trn_len  (cfg_trn_len),
        .cfg_trn_cnt  (cfg_trn_cnt),
        .cfg_data_awv (cfg_data_awv),
        .pay_valid    (pay_valid),
        .pay_last     (pay_last),
        .state        (state),
        .cnt          (cnt),
        .fld          (fld),
        .data_awv     (data_awv)
    );

    for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
        framer_wave_rom #(
            .SW(SW), .DEPTH(DEPTH), .AMP(AMP), .MASK(wave_mask(w))
        ) u_rom (
            .idx    (cnt[IW-1:0]),
            .sample (wave[w])
        );
    end

    framer_awv #(.AW(AW), .CW(CW)) u_awv (
        .in_trn (state == FR_TRN),
        .fld    (fld),
        .base   (data_awv),
        .awv    (awv_idx)
    );

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        pay_ready = 1'b0;
        unique case (state)
            FR_STF: begin
                out_valid = 1'b1;
                out_data  = wave[0];
            end
            FR_CEF: begin
                out_valid = 1'b1;
                out_data  = wave[1];
            end
            FR_PAY: begin
                pay_ready = 1'b1;
                out_valid = pay_valid;
                out_data  = pay_data;
            end
            FR_TRN: begin
                out_valid = 1'b1;
                out_data  = wave[2];
            end
            FR_IDLE, FR_DONE: ;
            default: ;
        endcase
        out_field = state;
    end
endmodule

// File: rtl/framer_chk.sv
module framer_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pay_ready,
    input logic          out_valid,
    input logic [2:0]    out_field,
    input logic [AW-1:0] awv_idx
);
    p_ready_only_pay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> out_field == 3'd3);

    p_quiet_idle_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_field == 3'd0 || out_field == 3'd5) |-> !out_valid);

    p_done_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_field == 3'd5 |=> out_field == 3'd0);

    p_stf_then_cef_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_field == 3'd1 |=> (out_field == 3'd1 || out_field == 3'd2));

    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_field != 3'd0 && out_field != 3'd1) |=> out_field != 3'd1);

    p_awv_held_cef_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_field == 3'd2 || out_field == 3'd3) |-> $stable(awv_idx));

    p_awv_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_field == 3'd4 && $past(out_field) == 3'd4 && awv_idx != $past(awv_idx))
        |-> awv_idx == AW'($past(awv_idx) + 1'b1));
endmodule

bind mmw_tx_framer framer_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pay_ready (pay_ready),
    .out_valid (out_valid),
    .out_field (out_field),
    .awv_idx   (awv_idx)
);

// File: tb/tb_mmw_tx_framer.sv
module tb_mmw_tx_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] cfg_stf_len = '0, cfg_cef_len = '0, cfg_pay_len = '0, cfg_trn_len = '0;
    logic [3:0]  cfg_trn_cnt = '0;
    logic [5:0]  cfg_data_awv = '0;
    logic        pay_valid, pay_last, pay_ready, out_valid;
    logic [15:0] pay_data, out_data;
    logic [2:0]  out_field;
    logic [5:0]  awv_idx;

    // payload source controls
    logic        src_clr = 1'b0, src_gap = 1'b0, src_last_en = 1'b0;
    logic [15:0] src_base = '0;
    int          src_last_at = 0;
    int          src_idx = 0;
    logic [1:0]  tick = '0;

    int checks = 0, failures = 0, mon_checks = 0, mon_fail = 0;
    bit finished = 0;
    logic [24:0] expq[$];

    always #2.5 clk = ~clk;

    mmw_tx_framer dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_stf_len(cfg_stf_len), .cfg_cef_len(cfg_cef_len),
        .cfg_pay_len(cfg_pay_len), .cfg_trn_len(cfg_trn_len),
        .cfg_trn_cnt(cfg_trn_cnt), .cfg_data_awv(cfg_data_awv),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_last(pay_last),
        .pay_ready(pay_ready), .out_valid(out_valid), .out_data(out_data),
        .out_field(out_field), .awv_idx(awv_idx)
    );

    assign pay_valid = (src_idx < 16) && !(src_gap && tick == 2'b01);
    assign pay_data  = src_base + 16'(src_idx);
    assign pay_last  = src_last_en && (src_idx == src_last_at);

    always @(posedge clk) begin
        tick <= tick + 1'b1;
        if (src_clr)                     src_idx <= 0;
        else if (pay_valid && pay_ready) src_idx <= src_idx + 1;
    end

    function automatic logic [15:0] wave(input logic [15:0] mask, input int i);
        logic [15:0] ii;
        ii = 16'(i % 32);
        return (^(ii & mask)) ? 16'(-8192) : 16'(8192);
    endfunction

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: one queue entry per valid output sample
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            mon_checks++;
            if (expq.size() == 0) begin
                mon_fail++;
                $display("FAIL R8 unexpected sample actual=%0d expected=none", out_data);
            end else begin
                logic [24:0] e;
                e = expq.pop_front();
                if ({out_field, awv_idx, out_data} !== e) begin
                    mon_fail++;
                    $display("FAIL R2/R3/R4/R5/R6/R7 field/awv/data actual=%0h expected=%0h",
                             {out_field, awv_idx, out_data}, e);
                end
            end
        end
    end

    task automatic run_frame(input int stf, input int cef, input int pay, input int tcnt,
                             input int tlen, input logic [5:0] awv, input bit last_en,
                             input int last_at, input bit gap, input int restart_at,
                             input logic [15:0] base);
        int n;
        // R3 short and estimation fields, R9 zero length as one
        for (int i = 0; i < eff(stf); i++) expq.push_back({3'd1, awv, wave(16'h13, i)});
        for (int i = 0; i < eff(cef); i++) expq.push_back({3'd2, awv, wave(16'h0D, i)});
        // R5 payload end
        n = eff(pay);
        if (last_en && last_at + 1 < n) n = last_at + 1;
        for (int i = 0; i < n; i++) expq.push_back({3'd3, awv, base + 16'(i)});
        // R6 training fields, R7 beam per field
        for (int k = 0; k < tcnt; k++)
            for (int i = 0; i < eff(tlen); i++)
                expq.push_back({3'd4, 6'(awv + 6'(k) + 6'd1), wave(16'h1A, i)});
        @(negedge clk);
        cfg_stf_len = 12'(stf); cfg_cef_len = 12'(cef); cfg_pay_len = 12'(pay);
        cfg_trn_len = 12'(tlen); cfg_trn_cnt = 4'(tcnt); cfg_data_awv = awv;
        src_base = base; src_gap = gap; src_last_en = last_en; src_last_at = last_at;
        src_clr = 1'b1;
        @(negedge clk);
        src_clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: config changed after start must not matter
        cfg_data_awv = ~awv; cfg_stf_len = 12'd1;
        check(out_field == 3'd1, "R2 frame begins with STF", out_field, 1);
        if (restart_at > 0) begin
            repeat (restart_at) @(negedge clk);
            start = 1'b1;  // R8: ignored start
            @(negedge clk);
            start = 1'b0;
        end
        while (out_field != 3'd5) @(negedge clk);
        check(!out_valid, "R10 DONE quiet", out_valid, 0);
        check(expq.size() == 0, "R2 all fields emitted before DONE", expq.size(), 0);
        @(negedge clk);
        check(out_field == 3'd0, "R10 IDLE after DONE", out_field, 0);
        check(awv_idx == awv, "R7 data beam restored", awv_idx, awv);
        check(!pay_ready, "R4 ready low outside PAY", pay_ready, 0);
        repeat (6) @(negedge clk);
        check(out_field == 3'd0, "R8 no second frame", out_field, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid, "R1 reset out_valid", out_valid, 0);
        check(!pay_ready, "R1 reset pay_ready", pay_ready, 0);
        check(out_field == 3'd0, "R1 reset field IDLE", out_field, 0);
        check(awv_idx == 6'd0, "R1 reset awv", awv_idx, 0);
        rst_n = 1'b1;
        // frame A: full payload with stalls, two training fields
        run_frame(4, 3, 6, 2, 3, 6'd5, 1'b0, 0, 1'b1, 0, 16'h1000);
        // frame B: early last, no training, zero CEF length
        run_frame(2, 0, 10, 0, 4, 6'd9, 1'b1, 2, 1'b0, 0, 16'h2000);
        // frame C: long STF wraps table, beam wraps, restart ignored
        run_frame(40, 2, 2, 3, 2, 6'd63, 1'b0, 0, 1'b0, 10, 16'h3000);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1,
                     failures + mon_fail + 1);
            $finish;
        end
    end
endmodule